// File: doc/BRIEF.md
# Address-Mapped Ready Wait-State Generator

This block stretches the two phases of a multiplexed processor bus cycle. While the address strobe is high, it holds the address-ready output low for a programmed number of clocks. When the address strobe falls, it takes the latched address and picks a data-phase wait count. The count comes from one of two packed registers, one for memory and one for I/O. Each register holds one 4-bit field per quarter of the 16-bit space, and the address's top two bits select the field. While the data strobe is high, the count runs down, and data-ready goes high once it reaches zero.

Two inputs change how this works. A long-delay enable makes memory accesses in the lowest quarter count pulses of an external 1 ms tick instead of clocks, which gives ready delays on the millisecond scale. An external override input forces data-ready low whatever the count is. The registers are loaded through a simple write port. After reset every setting is at its slowest value.

Top module: `waitgen_top`

## Requirements
- R1: Memory field select: address bits [15:14] give quadrant q, and memory cycles use bits [4q+3:4q] of the memory wait register as the data-phase wait count (0 to 15 clocks).
- R2: After reset, both wait registers read FFFF, the address wait count is 3 and the I/O extend bit is 0. In idle, addrReady is low and dataReady is high.
- R3: After the address strobe rises, addrReady stays low for the first N sampled strobe-high clocks (N = address wait count) and then goes high. addrReady is always low while the strobe is low.
- R4: The data wait count is loaded on the clock edge that sees the address strobe fall. It then decrements once per clock while dataStrobe is high, and dataReady is low for exactly that many data-strobe clocks.
- R5: When busIsMem is 0, the count comes from the I/O wait register, which uses the same field layout.
- R6: With the extend bit at 0, I/O quadrant 0 uses its field and I/O quadrants 1 to 3 get zero waits. With the extend bit at 1, every I/O quadrant uses its own field.
- R7: While forceNotReady is 1, dataReady is low.
- R8: With longEn at 1, a memory access in quadrant 0 decrements its count only on clocks where msTick is 1, so dataReady stays low until that many ticks have been seen. Other quadrants keep counting clocks.
- R9: Write port: regSel 0 writes the memory register, 1 writes the I/O register, 2 writes the control register (bits [1:0] address wait count, bit 2 extend). regSel 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addrStrobe | input | 1 | Address strobe, active high |
| dataStrobe | input | 1 | Data strobe, active high |
| busAddr | input | 16 | Latched bus address |
| busIsMem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| regWrEn | input | 1 | Register write enable |
| regSel | input | 2 | Register select for the write port |
| regWrData | input | 16 | Register write data |
| forceNotReady | input | 1 | External override, 1 forces dataReady low |
| longEn | input | 1 | Enables millisecond counting for memory quadrant 0 |
| msTick | input | 1 | One-clock pulse per millisecond |
| addrReady | output | 1 | Address-phase ready |
| dataReady | output | 1 | Data-phase ready |

## Verification
The bench aims at the quadrant boundaries (3FFF, 4000, BFFF, C000), where a design that decodes the wrong address bits picks the neighbouring field and returns a wrong wait count. It checks the slowest-value reset state: a design that clears its registers answers with zero waits at once. It checks that the extend bit gates the upper I/O quadrants, that a write to the unused select leaves the memory field intact, and that the override holds ready low even when the count is zero. In long mode it runs many clocks with no tick, so a design that counts clocks instead of ticks releases ready early.

// File: rtl/waitgen_pkg.sv
package waitgen_pkg;
  localparam int ADDR_W  = 16;
  localparam int FIELD_W = 4;
  localparam int QUADS   = 4;
  localparam int AWAIT_W = 2;
  localparam int QSEL_W  = $clog2(QUADS);
  localparam int REG_W   = FIELD_W * QUADS;

  typedef enum logic [1:0] {
    SEL_MEM  = 2'd0,
    SEL_IO   = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_NONE = 2'd3
  } regsel_e;

  typedef struct packed {
    logic addrLoad;
    logic addrStep;
    logic dataLoad;
    logic dataStep;
  } wg_ctl_t;
endpackage

// File: rtl/waitgen_ctrl.sv
module waitgen_ctrl
  import waitgen_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    addrStrobe,
  input  logic    dataStrobe,
  output wg_ctl_t ctl
);
  logic asPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) asPrev <= 1'b0;
    else       asPrev <= addrStrobe;
  end

  always_comb begin
    ctl.addrLoad = !addrStrobe;
    ctl.addrStep = addrStrobe;
    ctl.dataLoad = asPrev && !addrStrobe;
    ctl.dataStep = dataStrobe && !(asPrev && !addrStrobe);
  end

  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.dataLoad |=> !ctl.dataLoad); // R4
endmodule

// File: rtl/waitgen_dp.sv
module waitgen_dp
  import waitgen_pkg::*;
#(
  parameter int P_ADDR_W  = ADDR_W,
  parameter int P_FIELD_W = FIELD_W,
  parameter int P_QUADS   = QUADS,
  parameter int P_AWAIT_W = AWAIT_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wg_ctl_t              ctl,
  input  logic                 addrStrobe,
  input  logic                 dataStrobe,
  input  logic [P_ADDR_W-1:0]  busAddr,
  input  logic                 busIsMem,
  input  logic                 regWrEn,
  input  logic [1:0]           regSel,
  input  logic [P_FIELD_W*P_QUADS-1:0] regWrData,
  input  logic                 forceNotReady,
  input  logic                 longEn,
  input  logic                 msTick,
  output logic                 addrReady,
  output logic                 dataReady
);
  localparam int LQSEL = $clog2(P_QUADS);
  localparam int LREG  = P_FIELD_W * P_QUADS;

  logic [LREG-1:0]      memWaits, ioWaits;
  logic [P_AWAIT_W-1:0] addrWaits;
  logic                 ioExtend;
  logic [P_FIELD_W-1:0] memField [P_QUADS];
  logic [P_FIELD_W-1:0] ioField  [P_QUADS];
  logic [LQSEL-1:0]     quad;
  logic [P_FIELD_W-1:0] selField;
  logic                 useLong;
  logic [P_AWAIT_W-1:0] aCnt;
  logic [P_FIELD_W-1:0] dCnt;
  logic                 longMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memWaits  <= '1;
      ioWaits   <= '1;
      addrWaits <= '1;
      ioExtend  <= 1'b0;
    end else if (regWrEn) begin
      case (regsel_e'(regSel))
        SEL_MEM: memWaits <= regWrData;
        SEL_IO:  ioWaits  <= regWrData;
        SEL_CTL: begin
          addrWaits <= regWrData[P_AWAIT_W-1:0];
          ioExtend  <= regWrData[P_AWAIT_W];
        end
        default: ;
      endcase
    end
  end

  for (genvar q = 0; q < P_QUADS; q++) begin : g_fields
    assign memField[q] = memWaits[q*P_FIELD_W +: P_FIELD_W];
    if (q == 0) begin : g_base
      assign ioField[q] = ioWaits[q*P_FIELD_W +: P_FIELD_W];
    end else begin : g_upper
      assign ioField[q] = ioExtend ? ioWaits[q*P_FIELD_W +: P_FIELD_W] : '0;
    end
  end

  assign quad     = busAddr[P_ADDR_W-1 -: LQSEL];
  assign selField = busIsMem ? memField[quad] : ioField[quad];
  assign useLong  = longEn && busIsMem && (quad == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aCnt <= '1;
    end else if (ctl.addrLoad) begin
      aCnt <= addrWaits;
    end else if (ctl.addrStep && aCnt != '0) begin
      aCnt <= aCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dCnt     <= '0;
      longMode <= 1'b0;
    end else if (ctl.dataLoad) begin
      dCnt     <= selField;
      longMode <= useLong;
    end else if (ctl.dataStep && dCnt != '0 && (!longMode || msTick)) begin
      dCnt <= dCnt - 1'b1;
    end
  end

  assign addrReady = addrStrobe && (aCnt == '0);
  assign dataReady = (dCnt == '0) && !forceNotReady;

  AST_ADDR_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    !addrStrobe |=> aCnt == $past(addrWaits)); // R3

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!dataStrobe && !ctl.dataLoad) |=> $stable(dCnt)); // R4

  AST_DATA_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (dataStrobe && !ctl.dataLoad && !longMode && dCnt != '0)
      |=> dCnt == P_FIELD_W'($past(dCnt) - 1'b1)); // R4

  AST_LONG_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (longMode && !msTick && !ctl.dataLoad) |=> $stable(dCnt)); // R8

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ($past(dCnt) == '0 && !$past(ctl.dataLoad)) |-> dCnt == '0); // R4
endmodule

// File: rtl/waitgen_top.sv
module waitgen_top
  import waitgen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        addrStrobe,
  input  logic        dataStrobe,
  input  logic [15:0] busAddr,
  input  logic        busIsMem,
  input  logic        regWrEn,
  input  logic [1:0]  regSel,
  input  logic [15:0] regWrData,
  input  logic        forceNotReady,
  input  logic        longEn,
  input  logic        msTick,
  output logic        addrReady,
  output logic        dataReady
);
  wg_ctl_t ctl;

  waitgen_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .addrStrobe (addrStrobe),
    .dataStrobe (dataStrobe),
    .ctl        (ctl)
  );

  waitgen_dp u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .addrStrobe    (addrStrobe),
    .dataStrobe    (dataStrobe),
    .busAddr       (busAddr),
    .busIsMem      (busIsMem),
    .regWrEn       (regWrEn),
    .regSel        (regSel),
    .regWrData     (regWrData),
    .forceNotReady (forceNotReady),
    .longEn        (longEn),
    .msTick        (msTick),
    .addrReady     (addrReady),
    .dataReady     (dataReady)
  );

  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (forceNotReady && !$past(forceNotReady)) |-> !dataReady); // R7
endmodule

// File: tb/waitgen_top_bench.sv
module waitgen_top_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic addrStrobe = 0, dataStrobe = 0, busIsMem = 1, regWrEn = 0;
  logic forceNotReady = 0, longEn = 0, msTick = 0;
  logic [15:0] busAddr = '0, regWrData = '0;
  logic [1:0] regSel = '0;
  logic addrReady, dataReady;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  waitgen_top u_waitgen_top (
    .clk(clk), .rstN(rstN), .addrStrobe(addrStrobe), .dataStrobe(dataStrobe),
    .busAddr(busAddr), .busIsMem(busIsMem), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .forceNotReady(forceNotReady), .longEn(longEn),
    .msTick(msTick), .addrReady(addrReady), .dataReady(dataReady)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    regWrEn = 1; regSel = sel; regWrData = val;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic runCycle(input logic mem, input logic [15:0] addr,
                          input int expA, input int expD, input string req);
    int aLow, dLow;
    @(negedge clk);
    busAddr = addr; busIsMem = mem; addrStrobe = 1;
    #1;
    aLow = 0;
    while (!addrReady && aLow < 40) begin
      aLow++;
      @(negedge clk); #1;
    end
    check(aLow == expA, {req, " addr waits"}, aLow, expA);
    @(negedge clk);
    addrStrobe = 0;
    @(negedge clk);
    dataStrobe = 1;
    #1;
    dLow = 0;
    while (!dataReady && dLow < 40) begin
      dLow++;
      @(negedge clk); #1;
    end
    check(dLow == expD, {req, " data waits"}, dLow, expD);
    @(negedge clk);
    dataStrobe = 0;
  endtask

  task automatic testReset();
    #1;
    check(addrReady == 0, "R2 R3 idle addrReady", addrReady, 0);
    check(dataReady == 1, "R2 idle dataReady", dataReady, 1);
    runCycle(1, 16'h8000, 3, 15, "R2 mem reset");
    runCycle(0, 16'h0010, 3, 15, "R2 R5 io reset");
    runCycle(0, 16'h4000, 3, 0, "R2 R6 io extend default");
  endtask

  task automatic testMemQuads();
    writeReg(2'd0, 16'h3A51);
    writeReg(2'd2, 16'h0001);
    runCycle(1, 16'h0123, 1, 1, "R1 R9 q0");
    runCycle(1, 16'h3FFF, 1, 1, "R1 q0 top");
    runCycle(1, 16'h4000, 1, 5, "R1 q1");
    runCycle(1, 16'hBFFF, 1, 10, "R1 q2");
    runCycle(1, 16'hC000, 1, 3, "R1 q3");
    writeReg(2'd2, 16'h0000);
    runCycle(1, 16'hF000, 0, 3, "R3 zero addr waits");
  endtask

  task automatic testIo();
    writeReg(2'd1, 16'h7425);
    runCycle(0, 16'h0005, 0, 5, "R5 io q0");
    runCycle(0, 16'h5000, 0, 0, "R6 io q1 ext off");
    runCycle(0, 16'hC000, 0, 0, "R6 io q3 ext off");
    writeReg(2'd2, 16'h0004);
    runCycle(0, 16'h5000, 0, 2, "R6 io q1 ext on");
    runCycle(0, 16'h8000, 0, 4, "R6 io q2 ext on");
    runCycle(0, 16'hC000, 0, 7, "R6 io q3 ext on");
    runCycle(1, 16'h4000, 0, 5, "R5 mem still mem reg");
  endtask

  task automatic testIgnoredSel();
    writeReg(2'd3, 16'h0000);
    runCycle(1, 16'h4000, 0, 5, "R9 sel3 no effect");
  endtask

  task automatic testForce();
    @(negedge clk);
    forceNotReady = 1; #1;
    check(dataReady == 0, "R7 forced low idle", dataReady, 0);
    @(negedge clk);
    forceNotReady = 0; #1;
    check(dataReady == 1, "R7 released", dataReady, 1);
  endtask

  task automatic testLong();
    writeReg(2'd0, 16'h3A52);
    longEn = 1;
    @(negedge clk);
    busAddr = 16'h0100; busIsMem = 1; addrStrobe = 1;
    @(negedge clk);
    addrStrobe = 0;
    @(negedge clk);
    dataStrobe = 1;
    for (int i = 0; i < 20; i++) @(negedge clk);
    #1;
    check(dataReady == 0, "R8 no tick holds", dataReady, 0);
    @(negedge clk); msTick = 1;
    @(negedge clk); msTick = 0; #1;
    check(dataReady == 0, "R8 one tick", dataReady, 0);
    @(negedge clk); msTick = 1;
    @(negedge clk); msTick = 0; #1;
    check(dataReady == 1, "R8 two ticks", dataReady, 1);
    @(negedge clk);
    dataStrobe = 0;
    runCycle(1, 16'h4000, 0, 5, "R8 other quadrant clocks");
    longEn = 0;
    runCycle(1, 16'h0100, 0, 2, "R8 off counts clocks");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testMemQuads();
    testIo();
    testIgnoredSel();
    testForce();
    testLong();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule